// File: doc/BRIEF.md
# Redundant-Aligned System Timing Generator

This block turns one master clock into the timing skeleton of a system: a set of binary-divided clock enables, a frame-rate enable, a long-period master sync pulse and a master count that advances once per sync period. Every derived signal is a single-cycle enable in the master clock domain, taken from one shared phase counter, so the enables always line up with each other. With default parameters and a 32.768 MHz master clock, the enables run at 16.384, 8.192, 4.096 and 2.048 MHz. The frame enable runs at 8 kHz and the master sync repeats every 60 ms.

Two of these generators are used as a redundant pair. The active unit drives its master sync to the partner. The standby unit takes the partner's pulse and pulls its own phase counter into line with it. The two units then produce the same enables in the same cycles, and a switch-over does not disturb the timing. If the partner's pulse stops arriving, the standby unit raises a loss-of-sync flag and keeps running on its own.

The master count is sent out MSB first on a three-wire serial link (clock, data, frame). A fresh value is captured at each master sync.

Top module: `tgen_top`

## Requirements
- R1: A phase counter steps through 0 to SYNC_DIV-1 and wraps. The master sync enable is high for exactly the cycles in which the phase is 0. The first such cycle is the first cycle after reset is released, and after that it repeats every SYNC_DIV cycles.
- R2: Divider enable k (k = 0 to NDIV-1) divides the master clock by 2^(k+1). It is high in the cycles where the phase is a multiple of 2^(k+1), so every divider enable is high in each master sync cycle.
- R3: The frame enable is high in the cycles where the phase is a multiple of FRAME_DIV, a power of two of at least 2^NDIV that divides SYNC_DIV.
- R4: When mode_standby is 0 (active), sync_out equals the master sync enable. When mode_standby is 1 (standby), sync_out stays 0.
- R5: In standby, a clock edge that samples sync_in high sets the phase to 1 for the next cycle, so the phase is 0 in the cycle of the received pulse. If the unit is already aligned, the pulse changes nothing.
- R6: In active mode, sync_in has no effect on the phase or on any enable.
- R7: In standby, loss_of_sync rises on the (SYNC_DIV+1)-th consecutive edge that samples sync_in low. It clears on an edge that samples sync_in high or active mode. While the flag is set, the enables keep running freely.
- R8: The master count (CNT_W bits, wrapping) goes up by one on each own master sync. The new value is captured for transmission in that same cycle.
- R9: After each master sync, ser_frm is high for 2*CNT_W cycles, starting in the next cycle. Each bit takes two cycles, first with ser_clk low and then with ser_clk high. ser_dat holds the bit for both cycles, and the bits go out MSB first.
- R10: While reset is high, all enables, sync_out, loss_of_sync and the serial outputs are 0, and the phase and the master count return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_standby | input | 1 | 0 = active unit, 1 = standby unit |
| sync_in | input | 1 | Master sync pulse from the partner unit |
| sync_out | output | 1 | Master sync pulse to the partner unit |
| msync_ce | output | 1 | Master sync enable, once per SYNC_DIV cycles |
| frame_ce | output | 1 | Frame-rate enable, once per FRAME_DIV cycles |
| div_ce | output | NDIV | Binary divider enables, bit k divides by 2^(k+1) |
| loss_of_sync | output | 1 | Partner pulse missing for more than a period in standby |
| ser_clk | output | 1 | Serial bit clock for the master count |
| ser_dat | output | 1 | Serial data, MSB first |
| ser_frm | output | 1 | Serial word frame |

## Verification
A pulse from the partner can arrive in the same cycle as the unit's own phase wrap. That is the aligned case, and it must leave every enable, the count and the serial word unchanged. The bench provokes this by driving sync_in exactly in the cycles where its phase model reads 0. It also drives pulses at other phases, in both modes. For each case it compares the number of cycles to the next own master sync with the value the requirements give, and it compares every enable with the phase model in every cycle.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

    typedef enum logic {
        MODE_ACTIVE  = 1'b0,
        MODE_STANDBY = 1'b1
    } red_mode_e;

    typedef struct packed {
        logic sclk;
        logic sdat;
        logic sfrm;
    } ser_bus_t;

    typedef struct packed {
        logic msync;
        logic frame;
    } tick_t;

endpackage

// File: rtl/tgen_phase.sv
module tgen_phase
    import tgen_pkg::*;
#(
    parameter int SYNC_DIV = 1966080,
    parameter int PH_W     = $clog2(SYNC_DIV)
) (
    input  logic            clk,
    input  logic            rst,
    input  red_mode_e       mode,
    input  logic            sync_in,
    output logic            live,
    output logic [PH_W-1:0] phase
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SYNC_DIV - 1);

    logic            realign;
    logic [PH_W-1:0] phase_nxt;

    always_comb begin
        realign = (mode == MODE_STANDBY) && sync_in;
        if (realign) begin
            phase_nxt = PH_W'(1);
        end else if (phase == PH_LAST) begin
            phase_nxt = '0;
        end else begin
            phase_nxt = phase + PH_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live  <= 1'b0;
            phase <= '0;
        end else begin
            live <= 1'b1;
            if (live) begin
                phase <= phase_nxt;
            end
        end
    end

    // R1: the phase never leaves its period
    assert_phase_bound_R1: assert property (@(posedge clk) disable iff (rst)
        phase <= PH_LAST);

    // R5: a partner pulse in standby puts us one step past phase zero
    assert_realign_R5: assert property (@(posedge clk) disable iff (rst)
        (live && mode == MODE_STANDBY && sync_in) |=> (phase == PH_W'(1)));

    // R6: in active mode the phase just counts, whatever sync_in does
    assert_active_step_R6: assert property (@(posedge clk) disable iff (rst)
        (live && mode == MODE_ACTIVE && phase != PH_LAST)
            |=> (phase == $past(phase) + PH_W'(1)));

endmodule

// File: rtl/tgen_ticks.sv
module tgen_ticks
    import tgen_pkg::*;
#(
    parameter int SYNC_DIV  = 1966080,
    parameter int FRAME_DIV = 4096,
    parameter int NDIV      = 4,
    parameter int PH_W      = $clog2(SYNC_DIV)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            live,
    input  logic [PH_W-1:0] phase,
    output tick_t           tick,
    output logic [NDIV-1:0] div_ce
);

    localparam int FR_W = $clog2(FRAME_DIV);

    always_comb begin
        tick.msync = live && (phase == '0);
        tick.frame = live && (phase[FR_W-1:0] == '0);
    end

    for (genvar k = 0; k < NDIV; k++) begin : g_bin
        assign div_ce[k] = live && (phase[k:0] == '0);
    end

    // R2: every divider enable is present in a master sync cycle
    assert_bins_on_sync_R2: assert property (@(posedge clk) disable iff (rst)
        tick.msync |-> (&div_ce));

    // R3: the frame enable only lands on slowest-divider cycles
    assert_frame_on_bin_R3: assert property (@(posedge clk) disable iff (rst)
        tick.frame |-> div_ce[NDIV-1]);

    // R1: master sync implies a frame tick
    assert_sync_is_frame_R1: assert property (@(posedge clk) disable iff (rst)
        tick.msync |-> tick.frame);

endmodule

// File: rtl/tgen_syncmon.sv
module tgen_syncmon
    import tgen_pkg::*;
#(
    parameter int SYNC_DIV = 1966080
) (
    input  logic      clk,
    input  logic      rst,
    input  red_mode_e mode,
    input  logic      sync_in,
    output logic      lost
);

    localparam int GAP_W = $clog2(SYNC_DIV + 1);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(SYNC_DIV);

    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_STANDBY || sync_in) begin
            gap  <= '0;
            lost <= 1'b0;
        end else if (gap == GAP_LIM) begin
            lost <= 1'b1;
        end else begin
            gap <= gap + GAP_W'(1);
        end
    end

    // R7: the flag only rises in standby after a pulse-free edge
    assert_lost_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(lost) |-> ($past(mode) == MODE_STANDBY && !$past(sync_in)));

    // R7: a received pulse clears the flag
    assert_lost_clear_R7: assert property (@(posedge clk) disable iff (rst)
        sync_in |=> !lost);

endmodule

// File: rtl/tgen_serout.sv
module tgen_serout
    import tgen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    output ser_bus_t ser
);

    localparam int BL_W = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] mcount;
    logic [CNT_W-1:0] shreg;
    logic [BL_W-1:0]  bits_left;
    logic             half;
    logic             busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcount    <= '0;
            shreg     <= '0;
            bits_left <= '0;
            half      <= 1'b0;
            busy      <= 1'b0;
        end else if (load) begin
            mcount    <= mcount + CNT_W'(1);
            shreg     <= mcount + CNT_W'(1);
            bits_left <= BL_W'(CNT_W);
            half      <= 1'b0;
            busy      <= 1'b1;
        end else if (busy) begin
            half <= ~half;
            if (half) begin
                shreg     <= {shreg[CNT_W-2:0], 1'b0};
                bits_left <= bits_left - BL_W'(1);
                if (bits_left == BL_W'(1)) begin
                    busy <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        ser.sfrm = busy;
        ser.sclk = busy && half;
        ser.sdat = busy && shreg[CNT_W-1];
    end

    // R9: a serial clock pulse is always inside the frame
    assert_sclk_framed_R9: assert property (@(posedge clk) disable iff (rst)
        ser.sclk |-> ser.sfrm);

    // R9: a new word starts with the clock low
    assert_word_start_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (ser.sfrm && !ser.sclk));

    // R8: the count only moves on a master sync
    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(mcount));

endmodule

// File: rtl/tgen_top.sv
module tgen_top
    import tgen_pkg::*;
#(
    parameter int SYNC_DIV  = 1966080,
    parameter int FRAME_DIV = 4096,
    parameter int NDIV      = 4,
    parameter int CNT_W     = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mode_standby,
    input  logic            sync_in,
    output logic            sync_out,
    output logic            msync_ce,
    output logic            frame_ce,
    output logic [NDIV-1:0] div_ce,
    output logic            loss_of_sync,
    output logic            ser_clk,
    output logic            ser_dat,
    output logic            ser_frm
);

    localparam int PH_W = $clog2(SYNC_DIV);

    red_mode_e       mode;
    logic            live;
    logic [PH_W-1:0] phase;
    tick_t           tick;
    ser_bus_t        ser;

    assign mode = red_mode_e'(mode_standby);

    tgen_phase #(
        .SYNC_DIV (SYNC_DIV),
        .PH_W     (PH_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .sync_in (sync_in),
        .live    (live),
        .phase   (phase)
    );

    tgen_ticks #(
        .SYNC_DIV  (SYNC_DIV),
        .FRAME_DIV (FRAME_DIV),
        .NDIV      (NDIV),
        .PH_W      (PH_W)
    ) u_ticks (
        .clk    (clk),
        .rst    (rst),
        .live   (live),
        .phase  (phase),
        .tick   (tick),
        .div_ce (div_ce)
    );

    tgen_syncmon #(
        .SYNC_DIV (SYNC_DIV)
    ) u_syncmon (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .sync_in (sync_in),
        .lost    (loss_of_sync)
    );

    tgen_serout #(
        .CNT_W (CNT_W)
    ) u_serout (
        .clk  (clk),
        .rst  (rst),
        .load (tick.msync),
        .ser  (ser)
    );

    assign msync_ce = tick.msync;
    assign frame_ce = tick.frame;
    assign sync_out = tick.msync && (mode == MODE_ACTIVE);
    assign ser_clk  = ser.sclk;
    assign ser_dat  = ser.sdat;
    assign ser_frm  = ser.sfrm;

    // R4: a standby unit never drives the partner
    assert_standby_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STANDBY) |-> !sync_out);

    // R10: the cycle after a reset edge is silent
    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!msync_ce && !frame_ce && div_ce == '0 && !sync_out
                 && !loss_of_sync && !ser_frm && !ser_clk && !ser_dat));

endmodule

// File: tb/test_tgen_top.sv
module test_tgen_top;

    localparam int CLK_PERIOD = 10;
    localparam int SD = 128;
    localparam int FD = 32;
    localparam int ND = 4;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_standby = 1'b0;
    logic          sync_in = 1'b0;
    logic          sync_out, msync_ce, frame_ce, loss_of_sync;
    logic [ND-1:0] div_ce;
    logic          ser_clk, ser_dat, ser_frm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tgen_top #(
        .SYNC_DIV  (SD),
        .FRAME_DIV (FD),
        .NDIV      (ND),
        .CNT_W     (CW)
    ) i_tgen_top (
        .clk          (clk),
        .rst          (rst),
        .mode_standby (mode_standby),
        .sync_in      (sync_in),
        .sync_out     (sync_out),
        .msync_ce     (msync_ce),
        .frame_ce     (frame_ce),
        .div_ce       (div_ce),
        .loss_of_sync (loss_of_sync),
        .ser_clk      (ser_clk),
        .ser_dat      (ser_dat),
        .ser_frm      (ser_frm)
    );

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    task automatic check(string req, string what, longint act, longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference model of the requirements, advanced at each rising edge
    bit ref_live = 1'b0;
    int ref_ph = 0;
    int ref_cnt = 0;
    int ref_gap = 0;
    bit ref_los = 1'b0;
    int exp_q[$];

    always @(posedge clk) begin
        if (rst) begin
            ref_live <= 1'b0;
            ref_ph   <= 0;
            ref_cnt  <= 0;
        end else begin
            ref_live <= 1'b1;
            if (ref_live) begin
                if (mode_standby && sync_in) ref_ph <= 1;
                else ref_ph <= (ref_ph == SD - 1) ? 0 : ref_ph + 1;
                if (ref_ph == 0) begin
                    ref_cnt <= (ref_cnt + 1) % (1 << CW);
                    exp_q.push_back((ref_cnt + 1) % (1 << CW));
                end
            end
        end
        if (rst || !mode_standby || sync_in) begin
            ref_gap <= 0;
            ref_los <= 1'b0;
        end else if (ref_gap == SD) begin
            ref_los <= 1'b1;
        end else begin
            ref_gap <= ref_gap + 1;
        end
    end

    // per-cycle monitor of the enables
    always @(negedge clk) begin
        if (!done) begin
            bit ems;
            ems = ref_live && (ref_ph == 0);
            if (!ref_live) begin
                check("R10", "quiet enables", {msync_ce, frame_ce, div_ce, sync_out}, 0);
            end else begin
                check("R1", "msync_ce", msync_ce, ems);
                for (int k = 0; k < ND; k++)
                    check("R2", $sformatf("div_ce[%0d]", k), div_ce[k],
                          (ref_ph % (2 << k)) == 0);
                check("R3", "frame_ce", frame_ce, (ref_ph % FD) == 0);
                check("R4", "sync_out", sync_out, ems && !mode_standby);
            end
            check("R7", "loss_of_sync", loss_of_sync, ref_los);
        end
    end

    // serial monitor: assembles words and pops the scoreboard
    logic [CW-1:0] word = '0;
    int nbits = 0;
    int frm_len = 0;

    always @(negedge clk) begin
        if (!done) begin
            if (ser_frm) frm_len++;
            else if (frm_len > 0) begin
                check("R9", "frame length", frm_len, 2 * CW);
                frm_len = 0;
            end
            if (ser_frm && ser_clk) begin
                word = {word[CW-2:0], ser_dat};
                nbits++;
                if (nbits == CW) begin
                    if (exp_q.size() == 0) begin
                        check("R8", "unexpected word", word, -1);
                    end else begin
                        check("R8", "serial count word", word, exp_q.pop_front());
                    end
                    nbits = 0;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #(CLK_PERIOD / 4);
    endtask

    task automatic wait_phase(int p);
        while (ref_ph != p) tick();
    endtask

    task automatic pulse();
        sync_in = 1'b1;
        tick();
        sync_in = 1'b0;
    endtask

    task automatic cycles_to_sync(output int n);
        n = 0;
        while (!msync_ce) begin
            tick();
            n++;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int nsync;
        repeat (5) tick();
        // R10: reset state
        check("R10", "msync_ce in reset", msync_ce, 0);
        check("R10", "ser_frm in reset", ser_frm, 0);
        check("R10", "loss_of_sync in reset", loss_of_sync, 0);
        rst = 1'b0;
        tick();
        check("R1", "sync in first cycle after reset", msync_ce, 1);

        // active mode, several periods with serial words
        repeat (3 * SD) tick();

        // R6: sync_in ignored in active mode
        wait_phase(50);
        pulse();
        cycles_to_sync(n);
        check("R6", "cycles to sync after ignored pulse", n, SD - 51);

        // R5: off-phase realign in standby
        mode_standby = 1'b1;
        repeat (SD / 2) tick();
        wait_phase(40);
        pulse();
        cycles_to_sync(n);
        check("R5", "cycles to sync after realign", n, SD - 1);

        // R5: aligned pulses coinciding with own wrap change nothing
        for (int p = 0; p < 3; p++) begin
            wait_phase(0);
            pulse();
            cycles_to_sync(n);
            check("R5", "cycles to sync with aligned pulse", n, SD - 1);
        end
        check("R7", "no loss while pulses arrive", loss_of_sync, 0);

        // R7: pulses stop, flag rises, enables keep running
        nsync = 0;
        for (int c = 0; c < 2 * SD + 4; c++) begin
            tick();
            if (msync_ce) nsync++;
        end
        check("R7", "loss flag after missing pulse", loss_of_sync, 1);
        check("R7", "free-running syncs while lost", nsync, 2);

        // R7: a pulse clears the flag
        wait_phase(70);
        pulse();
        check("R7", "loss flag cleared by pulse", loss_of_sync, 0);
        check("R5", "phase after realign from lost", msync_ce, 0);

        // R4: back to active, own sync driven out
        mode_standby = 1'b0;
        cycles_to_sync(n);
        check("R4", "sync_out in active sync cycle", sync_out, 1);
        repeat (2 * SD) tick();
        finish_run();
    end

endmodule